// File: doc/BRIEF.md
# Parallel Flash Programming Port Controller

This block sits between a set of slow, pin-level programming strobes and a 2K-byte nonvolatile code array. An external programmer never presents an address. It clears an internal counter with a rising edge on the reset pin, then steps the counter one location at a time with pulses on a step pin. A strobe that idles high and is pulsed low starts each operation. The operation is chosen by four select pins together with a high-voltage enable input. The controller times each byte write and lock-bit write by itself and reports progress in two ways: on an active-low busy pin, and by inverting bit 7 of the byte being written when that byte is read back during the write.

The array itself sits outside the block, behind a simple combinational-read, clocked-write memory port with a whole-array erase strobe. The block also holds two protection bits and answers a fixed two-byte signature. All durations are counted in cycles of a free-running reference clock, so the real 2 ms write and 10 ms erase become parameters.

Top module: `fpp_ctrl`

## Requirements
- R1: A rising edge on `prst_pin` sets the address counter to 0x000. A read that follows then shows array location 0.
- R2: Each rising edge on `step_pin` while idle adds one to the counter, and 0x7FF steps to 0x000.
- R3: A `step_pin` edge that arrives while `busy_n` is low leaves the counter unchanged.
- R4: Modes are decoded from `hv_en` and `sel` = {s3,s4,s5,s7} (bit 3 first). With `hv_en`=1: 0111 is byte write, 1111 is lock-1 write, 1100 is lock-2 write, 1000 is chip erase. With `hv_en`=0: 0011 is code read and 0000 is signature read. Any other combination starts nothing and drives `dout` to 0xFF.
- R5: In byte-write mode, the first clock edge that sees `prog_n` back high stores the byte and pulls `busy_n` low. `busy_n` stays low for exactly WR_CYCLES clock cycles and then returns high. Lock-bit writes follow the same timing.
- R6: A byte write stores the old contents ANDed with `din`, so writing to a location that is not blank can only clear bits.
- R7: While busy with a byte write, a code read of the address just written shows the inverse of the written bit 7 on `dout[7]`. After the write finishes, the read shows the true byte.
- R8: Chip erase takes effect only if `prog_n` was low for at least ERASE_CYCLES cycles. It fills the array with 0xFF and clears both lock bits. A shorter low pulse changes nothing.
- R9: With lock 1 set, a byte write is refused: `busy_n` stays high and the array keeps its contents.
- R10: With both locks set, a code read returns 0xFF. With lock 1 alone set, code reads are still allowed.
- R11: A signature read returns 0x1E at address 0, 0x21 at address 1 and 0x00 at any other address. Lock bits do not affect it.
- R12: A `prog_n` pulse that arrives while busy starts no new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| prst_pin | input | 1 | Counter-clear pin; acts on its rising edge |
| step_pin | input | 1 | Address step pin; acts on its rising edge |
| prog_n | input | 1 | Active-low program strobe |
| hv_en | input | 1 | High-voltage programming enable |
| sel | input | 4 | Mode select {s3,s4,s5,s7} |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read data pins |
| busy_n | output | 1 | Low while a self-timed write runs |
| mem_addr | output | 11 | Array address (the counter) |
| mem_rdata | input | 8 | Array read data at `mem_addr` |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array byte write strobe |
| mem_erase | output | 1 | Whole-array erase strobe |

## Verification
The bench counts the exact number of cycles `busy_n` stays low. A sequencer that is off by one would report the wrong count. It holds the erase strobe just short of the limit and just past it. A design that compares with the wrong bound would erase when it should not, or fail to erase. It steps the counter across 0x7FF, writes a byte that is not blank, and pulses the step and program pins during a write. A design that does not wrap, that overwrites instead of ANDing, or that still accepts strobes while busy would leave a different byte at the observed address. Lock checks confirm that lock 1 alone blocks writes but not reads, that both locks hide the code but not the signature, and that only a full erase releases them.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    M_NONE, M_WRITE, M_READ, M_LOCK1, M_LOCK2, M_ERASE, M_SIG
  } fpp_mode_e;

  // sel = {s3,s4,s5,s7}
  function automatic fpp_mode_e decode_mode(input logic hv, input logic [3:0] sel);
    fpp_mode_e m;
    m = M_NONE;
    if (hv) begin
      case (sel)
        4'b0111: m = M_WRITE;
        4'b1111: m = M_LOCK1;
        4'b1100: m = M_LOCK2;
        4'b1000: m = M_ERASE;
        default: m = M_NONE;
      endcase
    end else begin
      case (sel)
        4'b0011: m = M_READ;
        4'b0000: m = M_SIG;
        default: m = M_NONE;
      endcase
    end
    return m;
  endfunction

  // A cell can only lose ones when written.
  function automatic logic [DATA_W-1:0] merge_byte(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v);
    return old_v & new_v;
  endfunction

  // Polling view: top bit inverted while the write is in flight.
  function automatic logic [DATA_W-1:0] poll_view(input logic [DATA_W-1:0] d);
    return {~d[DATA_W-1], d[DATA_W-2:0]};
  endfunction
endpackage

// File: rtl/fpp_edge.sv
module fpp_edge #(
  parameter int N = 3,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise
);
  logic [N-1:0] pin_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q[i] <= IDLE[i];
      else        pin_q[i] <= pin[i];
    end
    assign rise[i] = pin[i] & ~pin_q[i];
  end
endmodule

// File: rtl/fpp_addr_cnt.sv
module fpp_addr_cnt #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic              hold,
  output logic [ADDR_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (step && !hold)  cnt <= cnt + 1'b1;
  end

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hold && !clr) |=> (cnt == $past(cnt) + 1'b1));
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> $stable(cnt));
endmodule

// File: rtl/fpp_seq.sv
module fpp_seq
  import fpp_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int WR_CYCLES    = 64,
  parameter int ERASE_CYCLES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fpp_mode_e         mode,
  input  logic              prog_low,
  input  logic              prog_rise,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_erase,
  output logic              lock1,
  output logic              lock2,
  output logic              poll_on,
  output logic [ADDR_W-1:0] poll_addr,
  output logic [DATA_W-1:0] poll_data
);
  localparam int WT_W = $clog2(WR_CYCLES + 1);
  localparam int ET_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [WT_W-1:0] WT_LOAD = WT_W'(WR_CYCLES - 1);
  localparam logic [ET_W-1:0] ET_MAX  = ET_W'(ERASE_CYCLES);

  logic [WT_W-1:0] wtmr;
  logic [ET_W-1:0] elow;
  logic start_byte, start_lock, start_erase, accept;

  assign accept      = prog_rise && !busy;
  assign start_byte  = accept && (mode == M_WRITE) && !lock1;
  assign start_lock  = accept && ((mode == M_LOCK1) || (mode == M_LOCK2));
  assign start_erase = accept && (mode == M_ERASE) && (elow == ET_MAX);

  assign mem_we    = start_byte;
  assign mem_wdata = merge_byte(rdata, din);

  // Low-time meter for the erase strobe, saturating at the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              elow <= '0;
    else if (!prog_low || mode != M_ERASE)   elow <= '0;
    else if (elow != ET_MAX)                 elow <= elow + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wtmr <= '0;
    end else if (start_byte || start_lock) begin
      busy <= 1'b1;
      wtmr <= WT_LOAD;
    end else if (busy) begin
      if (wtmr == '0) busy <= 1'b0;
      else            wtmr <= wtmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_on   <= 1'b0;
      poll_addr <= '0;
      poll_data <= '0;
    end else if (start_byte) begin
      poll_on   <= 1'b1;
      poll_addr <= addr;
      poll_data <= mem_wdata;
    end else if (start_lock || (busy && wtmr == '0)) begin
      poll_on   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock1     <= 1'b0;
      lock2     <= 1'b0;
      mem_erase <= 1'b0;
    end else begin
      mem_erase <= start_erase;
      if (start_erase) begin
        lock1 <= 1'b0;
        lock2 <= 1'b0;
      end else if (start_lock) begin
        if (mode == M_LOCK1) lock1 <= 1'b1;
        else                 lock2 <= 1'b1;
      end
    end
  end

  // R5
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> busy);
  // R12
  busy_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_we);
  // R8
  lk1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock1) |-> mem_erase);
  // R8
  lk2_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock2) |-> mem_erase);
endmodule

// File: rtl/fpp_ctrl.sv
module fpp_ctrl
  import fpp_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int WR_CYCLES    = 64,
  parameter int ERASE_CYCLES = 128,
  parameter logic [7:0] SIG0 = 8'h1E,
  parameter logic [7:0] SIG1 = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prst_pin,
  input  logic              step_pin,
  input  logic              prog_n,
  input  logic              hv_en,
  input  logic [3:0]        sel,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              busy_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_erase
);
  logic [2:0] rise;
  logic       busy, lock1, lock2, poll_on;
  logic [ADDR_W-1:0] cnt, poll_addr;
  logic [DATA_W-1:0] poll_data;
  fpp_mode_e mode;

  assign mode = decode_mode(hv_en, sel);

  fpp_edge #(.N(3), .IDLE(3'b100)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .pin({prog_n, step_pin, prst_pin}), .rise(rise)
  );

  fpp_addr_cnt #(.ADDR_W(ADDR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(rise[0]), .step(rise[1]),
    .hold(busy), .cnt(cnt)
  );

  fpp_seq #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES),
            .ERASE_CYCLES(ERASE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .prog_low(~prog_n),
    .prog_rise(rise[2]), .addr(cnt), .rdata(mem_rdata), .din(din),
    .busy(busy), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_erase(mem_erase), .lock1(lock1), .lock2(lock2),
    .poll_on(poll_on), .poll_addr(poll_addr), .poll_data(poll_data)
  );

  assign mem_addr = cnt;
  assign busy_n   = ~busy;

  always_comb begin
    dout = 8'hFF;
    case (mode)
      M_READ: begin
        if (lock1 && lock2)                      dout = 8'hFF;
        else if (poll_on && cnt == poll_addr)    dout = poll_view(poll_data);
        else                                     dout = mem_rdata;
      end
      M_SIG: begin
        if (cnt == ADDR_W'(0))      dout = SIG0;
        else if (cnt == ADDR_W'(1)) dout = SIG1;
        else                        dout = 8'h00;
      end
      default: dout = 8'hFF;
    endcase
  end

  // R7
  poll_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_on |-> busy);
endmodule

// File: tb/fpp_ctrl_test.sv
module fpp_ctrl_test;
  localparam int WR = 20;
  localparam int ER = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prst_pin = 1'b0, step_pin = 1'b0, prog_n = 1'b1, hv_en = 1'b0;
  logic [3:0] sel = 4'b0011;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, mem_rdata, mem_wdata;
  logic busy_n, mem_we, mem_erase;
  logic [10:0] mem_addr;
  logic [7:0] mem [0:2047];
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  fpp_ctrl #(.WR_CYCLES(WR), .ERASE_CYCLES(ER)) uut (
    .clk(clk), .rst_n(rst_n), .prst_pin(prst_pin), .step_pin(step_pin),
    .prog_n(prog_n), .hv_en(hv_en), .sel(sel), .din(din), .dout(dout),
    .busy_n(busy_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_erase(mem_erase)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_erase) for (int i = 0; i < 2048; i++) mem[i] <= 8'hFF;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic do_prst();
    @(negedge clk) prst_pin = 1'b1;
    @(negedge clk) prst_pin = 1'b0;
  endtask
  task automatic do_step();
    @(negedge clk) step_pin = 1'b1;
    @(negedge clk) step_pin = 1'b0;
  endtask
  task automatic set_mode(input logic hv, input logic [3:0] s);
    @(negedge clk) begin hv_en = hv; sel = s; end
  endtask
  task automatic pulse_prog(input int low);
    @(negedge clk) prog_n = 1'b0;
    nclk(low);
    prog_n = 1'b1;
  endtask
  task automatic read_at(input logic [7:0] exp, input string req);
    set_mode(1'b0, 4'b0011);
    #1 check(dout === exp, req, dout, exp);
  endtask
  task automatic wait_ready();
    for (int i = 0; i < 4 * WR && !busy_n; i++) @(negedge clk);
  endtask
  task automatic goto(input int a);
    do_prst();
    for (int i = 0; i < a; i++) do_step();
  endtask
  task automatic write_byte(input logic [7:0] d);
    set_mode(1'b1, 4'b0111);
    din = d;
    pulse_prog(1);
    @(negedge clk);
    wait_ready();
  endtask

  task automatic t_reset();
    #1 check(busy_n === 1'b1, "R5 reset busy_n", busy_n, 1);
    check(mem_we === 1'b0, "R5 reset mem_we", mem_we, 0);
  endtask

  task automatic t_counter();
    goto(3);
    read_at(8'hA3, "R2 step to 3");
    do_prst();
    #1 check(dout === 8'h96, "R1 clear", dout, 8'h96);
    for (int i = 0; i < 2047; i++) do_step();
    #1 check(dout === 8'hC3, "R2 top address", dout, 8'hC3);
    do_step();
    #1 check(dout === 8'h96, "R2 wrap", dout, 8'h96);
  endtask

  task automatic t_decode();
    goto(10);
    set_mode(1'b1, 4'b0011);
    #1 check(dout === 8'hFF, "R4 read at hv", dout, 8'hFF);
    din = 8'h00;
    pulse_prog(1);
    @(negedge clk);
    check(busy_n === 1'b1, "R4 no start hv read", busy_n, 1);
    set_mode(1'b0, 4'b0111);
    pulse_prog(1);
    @(negedge clk);
    check(busy_n === 1'b1, "R4 no start low-voltage write", busy_n, 1);
    read_at(8'hFF, "R4 byte untouched");
  endtask

  task automatic t_write_timing();
    int n;
    goto(5);
    set_mode(1'b1, 4'b0111);
    din = 8'h3C;
    pulse_prog(1);
    n = 0;
    for (int i = 0; i < 4 * WR; i++) begin
      @(negedge clk);
      if (busy_n) break;
      n++;
    end
    check(n == WR, "R5 busy length", n, WR);
    read_at(8'h3C, "R5 stored byte");
  endtask

  task automatic t_and();
    write_byte(8'hF0);
    read_at(8'h30, "R6 AND into non-blank");
  endtask

  task automatic t_poll();
    goto(6);
    set_mode(1'b1, 4'b0111);
    din = 8'h80;
    pulse_prog(1);
    set_mode(1'b0, 4'b0011);
    #1 check(dout[7] === 1'b0, "R7 polling bit", dout[7], 0);
    wait_ready();
    read_at(8'h80, "R7 true data after write");
  endtask

  task automatic t_busy_ignore();
    goto(7);
    set_mode(1'b1, 4'b0111);
    din = 8'h11;
    pulse_prog(1);
    do_step();
    din = 8'h00;
    pulse_prog(1);
    @(negedge clk);
    check(busy_n === 1'b0, "R12 still busy", busy_n, 0);
    wait_ready();
    read_at(8'h11, "R3 R12 counter held, second strobe dropped");
    do_step();
    #1 check(dout === 8'hFF, "R3 next byte untouched", dout, 8'hFF);
  endtask

  task automatic t_sig();
    set_mode(1'b0, 4'b0000);
    do_prst();
    #1 check(dout === 8'h1E, "R11 sig 0", dout, 8'h1E);
    do_step();
    #1 check(dout === 8'h21, "R11 sig 1", dout, 8'h21);
    do_step();
    #1 check(dout === 8'h00, "R11 sig 2", dout, 8'h00);
  endtask

  task automatic t_lock();
    set_mode(1'b1, 4'b1111);
    pulse_prog(1);
    @(negedge clk);
    wait_ready();
    goto(9);
    set_mode(1'b1, 4'b0111);
    din = 8'h00;
    pulse_prog(1);
    @(negedge clk);
    check(busy_n === 1'b1, "R9 locked write refused", busy_n, 1);
    read_at(8'hFF, "R9 byte kept");
    goto(5);
    read_at(8'h30, "R10 read allowed with lock 1");
    set_mode(1'b1, 4'b1100);
    pulse_prog(1);
    @(negedge clk);
    wait_ready();
    read_at(8'hFF, "R10 read hidden");
    set_mode(1'b0, 4'b0000);
    do_prst();
    #1 check(dout === 8'h1E, "R11 sig while locked", dout, 8'h1E);
  endtask

  task automatic t_erase();
    set_mode(1'b1, 4'b1000);
    pulse_prog(ER - 5);
    nclk(3);
    check(mem[5] === 8'h30, "R8 short erase ignored", mem[5], 8'h30);
    pulse_prog(ER + 5);
    nclk(3);
    check(mem[5] === 8'hFF && mem[7] === 8'hFF, "R8 array erased", mem[5], 8'hFF);
    goto(0);
    write_byte(8'h42);
    read_at(8'h42, "R8 locks cleared");
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
    mem[0] = 8'h96; mem[3] = 8'hA3; mem[2047] = 8'hC3;
    nclk(3);
    rst_n = 1'b1;
    nclk(2);
    t_reset();
    t_counter();
    t_decode();
    t_write_timing();
    t_and();
    t_poll();
    t_busy_ignore();
    t_sig();
    t_lock();
    t_erase();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule